// File: doc/BRIEF.md
# Floating-point control and status word

This unit holds the single control/status word of a scalar floating-point unit. Software reaches it through a small control-register port: one index is the live word, every other index reads as zero and ignores writes. The word carries the active rounding mode, five sticky exception flags, five trap enables, five per-operation cause bits and eight condition bits used by compare and conditional-branch logic.

An arithmetic datapath reports each finished operation with a strobe and five exception indications. The unit overwrites the cause field with that report, ORs it into the flags, and decides in the same cycle whether the operation traps. A trapping operation gets no commit enable and cannot change a condition bit, but its cause bits are still recorded. The same trap test runs again in the cycle after software writes the word, so software can raise a trap by writing a cause bit together with its enable.

Top module: `fpcsr_unit`

## Requirements
- R1: A synchronous active-high reset clears the whole word to zero. That selects round-to-nearest-even with every trap disabled, and trap_req and commit_en are low.
- R2: cr_rdata returns the word when cr_idx is 31 and zero for every other index, including index 0.
- R3: A write to index 31 stores wdata bits [16:0], [23] and [31:25]. Bits [22:17] and [24] always read zero. A write to any other index leaves the word unchanged.
- R4: round_mode follows word bits [1:0]: 0 is nearest-even, 1 is toward zero, 2 is toward +infinity, 3 is toward -infinity.
- R5: In the cycle after op_done, cause bits [16:12] equal op_exc. The exception order is bit 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid.
- R6: On op_done, flag bits [6:2] become their old value ORed with op_exc. An operation never clears a flag.
- R7: While op_done is high, trap_req is high in the same cycle exactly when op_exc AND enables [11:7] is nonzero. commit_en is the inverse of that test. The cause bits are recorded either way.
- R8: On op_done with cond_upd_en, and no trap, the selected condition bit takes cond_val in the next cycle. Select 0 maps to bit 23 and select k (1..7) maps to bit 24+k. A trapping operation leaves every condition bit unchanged.
- R9: In the cycle after a write to index 31, trap_req is high if the stored cause AND enables is nonzero. This lasts exactly one cycle.
- R10: With neither op_done nor a write in the previous cycle, trap_req and commit_en are low.
- R11: When a write and op_done occur in the same cycle, the operation is applied on top of the written word, and its trap test uses the written enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_idx | input | 5 | Control-register index for read and write |
| cr_wdata | input | 32 | Write data |
| cr_rdata | output | 32 | Read data for cr_idx (combinational) |
| op_done | input | 1 | Arithmetic operation completed this cycle |
| op_exc | input | 5 | Exceptions raised by that operation |
| cond_upd_en | input | 1 | The operation wants to update a condition bit |
| cond_sel | input | 3 | Which condition bit to update |
| cond_val | input | 1 | New condition bit value |
| csr_q | output | 32 | Current word |
| round_mode | output | 2 | Active rounding mode |
| trap_req | output | 1 | Trap request |
| commit_en | output | 1 | Result write-back allowed |

## Verification
The bench builds the unit with its default parameters: a 5-bit index, five exception kinds and eight condition bits. This small configuration allows every pairing of the 32 enable patterns with the 32 exception reports, so the trap, commit, cause and flag behaviour is checked for all 1024 combinations. The sweeps also cover all 32 read indexes, all 8 condition selects in both polarities, and all four rounding modes. A software-raised trap and a write that coincides with an operation are both exercised, each against an arithmetic model kept in the bench.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int CSR_W      = 32;
  localparam int IDX_W      = 5;
  localparam int EXC_N      = 5;
  localparam int COND_N     = 8;
  localparam int SEL_W      = $clog2(COND_N);
  localparam int RM_W       = 2;
  localparam int FLAG_LSB   = 2;
  localparam int EN_LSB     = FLAG_LSB + EXC_N;
  localparam int CAUSE_LSB  = EN_LSB + EXC_N;
  localparam int COND0_POS  = 23;
  localparam int CONDX_BASE = 24;

  typedef logic [CSR_W-1:0] csr_word_t;
  typedef logic [EXC_N-1:0] exc_t;

  typedef enum logic [RM_W-1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_TO_POS    = 2'd2,
    RM_TO_NEG    = 2'd3
  } rmode_e;

  function automatic int cond_pos(input int sel);
    return (sel == 0) ? COND0_POS : CONDX_BASE + sel;
  endfunction

  function automatic csr_word_t cond_mask();
    csr_word_t m;
    m = '0;
    for (int k = 0; k < COND_N; k++) m[cond_pos(k)] = 1'b1;
    return m;
  endfunction

  function automatic csr_word_t writable_mask();
    csr_word_t m;
    m = cond_mask();
    for (int i = 0; i < CAUSE_LSB + EXC_N; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic exc_t field_of(input csr_word_t w, input int lsb);
    return w[lsb +: EXC_N];
  endfunction

  function automatic exc_t enabled_hits(input csr_word_t w, input exc_t exc);
    return exc & field_of(w, EN_LSB);
  endfunction

  function automatic csr_word_t merge_report(input csr_word_t w, input exc_t exc);
    csr_word_t r;
    r = w;
    r[CAUSE_LSB +: EXC_N] = exc;
    r[FLAG_LSB +: EXC_N]  = field_of(w, FLAG_LSB) | exc;
    return r;
  endfunction
endpackage

// File: rtl/fpcsr_wr_merge.sv
module fpcsr_wr_merge
  import fpcsr_pkg::*;
#(
  parameter int CSR_INDEX = 31
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  csr_word_t        wdata,
  input  csr_word_t        cur,
  output csr_word_t        next,
  output logic             wr_hit
);
  localparam csr_word_t WMASK = writable_mask();

  assign wr_hit = wr_en && (idx == IDX_W'(CSR_INDEX));
  assign next   = wr_hit ? (wdata & WMASK) : cur;
endmodule

// File: rtl/fpcsr_exc_merge.sv
module fpcsr_exc_merge
  import fpcsr_pkg::*;
(
  input  logic      op_done,
  input  exc_t      exc,
  input  csr_word_t base,
  output csr_word_t next,
  output logic      op_trap
);
  exc_t hits;

  assign hits    = enabled_hits(base, exc);
  assign op_trap = op_done && (hits != '0);
  assign next    = op_done ? merge_report(base, exc) : base;
endmodule

// File: rtl/fpcsr_cond_upd.sv
module fpcsr_cond_upd
  import fpcsr_pkg::*;
(
  input  logic             upd_req,
  input  logic [SEL_W-1:0] sel,
  input  logic             val,
  input  csr_word_t        base,
  output csr_word_t        next
);
  logic [COND_N-1:0] dec;
  csr_word_t         pick;

  for (genvar k = 0; k < COND_N; k++) begin : g_dec
    assign dec[k] = (sel == SEL_W'(k));
  end

  always_comb begin
    pick = '0;
    for (int k = 0; k < COND_N; k++) pick[cond_pos(k)] = dec[k];
  end

  always_comb begin
    next = base;
    if (upd_req) next = (base & ~pick) | (val ? pick : '0);
  end
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int CSR_INDEX = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cr_wr_en,
  input  logic [IDX_W-1:0] cr_idx,
  input  logic [CSR_W-1:0] cr_wdata,
  output logic [CSR_W-1:0] cr_rdata,
  input  logic             op_done,
  input  logic [EXC_N-1:0] op_exc,
  input  logic             cond_upd_en,
  input  logic [SEL_W-1:0] cond_sel,
  input  logic             cond_val,
  output logic [CSR_W-1:0] csr_q,
  output logic [RM_W-1:0]  round_mode,
  output logic             trap_req,
  output logic             commit_en
);
  localparam csr_word_t WMASK = writable_mask();
  localparam csr_word_t CMASK = cond_mask();

  csr_word_t word_q, after_wr, after_op, after_cond;
  logic      wr_hit, wr_q, op_trap, sw_trap, cond_req;
  rmode_e    mode;

  fpcsr_wr_merge #(.CSR_INDEX(CSR_INDEX)) u_wr (
    .wr_en(cr_wr_en), .idx(cr_idx), .wdata(cr_wdata), .cur(word_q),
    .next(after_wr), .wr_hit(wr_hit)
  );

  fpcsr_exc_merge u_exc (
    .op_done(op_done), .exc(op_exc), .base(after_wr),
    .next(after_op), .op_trap(op_trap)
  );

  assign cond_req = op_done && cond_upd_en && !op_trap;

  fpcsr_cond_upd u_cond (
    .upd_req(cond_req), .sel(cond_sel), .val(cond_val),
    .base(after_op), .next(after_cond)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      word_q <= after_cond;
      wr_q   <= wr_hit;
    end
  end

  assign sw_trap    = wr_q && (enabled_hits(word_q, field_of(word_q, CAUSE_LSB)) != '0);
  assign trap_req   = op_trap || sw_trap;
  assign commit_en  = op_done && !op_trap;
  assign mode       = rmode_e'(word_q[RM_W-1:0]);
  assign round_mode = mode;
  assign csr_q      = word_q;
  assign cr_rdata   = (cr_idx == IDX_W'(CSR_INDEX)) ? word_q : '0;

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_q & ~WMASK) == '0);

  // R5
  cause_replace_chk: assert property (@(posedge clk) disable iff (rst)
    op_done |=> csr_q[CAUSE_LSB +: EXC_N] == $past(op_exc));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> ($past(csr_q[FLAG_LSB +: EXC_N]) & ~csr_q[FLAG_LSB +: EXC_N]) == '0);

  // R7
  trap_blocks_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (op_done && trap_req && !wr_q) |-> !commit_en);

  // R8
  cond_hold_on_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (op_trap && !wr_hit) |=> (csr_q & CMASK) == ($past(csr_q) & CMASK));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_done && !wr_q) |-> (!trap_req && !commit_en));
endmodule

// File: tb/fpcsr_unit_bench.sv
module fpcsr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cr_wr_en = 1'b0;
  logic [4:0]  cr_idx = '0;
  logic [31:0] cr_wdata = '0;
  logic [31:0] cr_rdata;
  logic        op_done = 1'b0;
  logic [4:0]  op_exc = '0;
  logic        cond_upd_en = 1'b0;
  logic [2:0]  cond_sel = '0;
  logic        cond_val = 1'b0;
  logic [31:0] csr_q;
  logic [1:0]  round_mode;
  logic        trap_req, commit_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m = '0;
  logic [31:0] wmask;

  always #5 clk = ~clk;

  fpcsr_unit u_fpcsr_unit (
    .clk(clk), .rst(rst), .cr_wr_en(cr_wr_en), .cr_idx(cr_idx), .cr_wdata(cr_wdata),
    .cr_rdata(cr_rdata), .op_done(op_done), .op_exc(op_exc), .cond_upd_en(cond_upd_en),
    .cond_sel(cond_sel), .cond_val(cond_val), .csr_q(csr_q), .round_mode(round_mode),
    .trap_req(trap_req), .commit_en(commit_en)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic int cpos(input int s);
    return (s == 0) ? 23 : 24 + s;
  endfunction

  function automatic logic hit_of(input logic [31:0] w, input logic [4:0] e);
    return ((e & w[11:7]) != 0);
  endfunction

  function automatic logic [31:0] apply_op(input logic [31:0] w, input logic [4:0] e,
                                           input logic cu, input int s, input logic v);
    logic [31:0] r;
    r = (w & ~(32'h1F << 12)) | ({27'd0, e} << 12);
    r = r | ({27'd0, e} << 2);
    if (cu && !hit_of(w, e)) r[cpos(s)] = v;
    return r;
  endfunction

  task automatic do_write(input logic [4:0] idx, input logic [31:0] d);
    logic exp_t;
    @(negedge clk);
    cr_wr_en = 1'b1; cr_idx = idx; cr_wdata = d;
    @(negedge clk);
    cr_wr_en = 1'b0; cr_idx = 5'd31;
    if (idx == 5'd31) m = d & wmask;
    exp_t = (idx == 5'd31) && (((m >> 12) & (m >> 7) & 32'h1F) != 0);
    check("R3 word after write", csr_q, m);
    check("R9 trap after write", {31'd0, trap_req}, {31'd0, exp_t});
    @(negedge clk);
    check("R9 trap lasts one cycle", {31'd0, trap_req}, 32'd0);
  endtask

  task automatic do_op(input logic [4:0] e, input logic cu, input int s, input logic v);
    logic h;
    @(negedge clk);
    op_done = 1'b1; op_exc = e; cond_upd_en = cu; cond_sel = 3'(s); cond_val = v;
    #1;
    h = hit_of(m, e);
    check("R7 trap_req", {31'd0, trap_req}, {31'd0, h});
    check("R7 commit_en", {31'd0, commit_en}, {31'd0, !h});
    @(negedge clk);
    op_done = 1'b0; cond_upd_en = 1'b0;
    m = apply_op(m, e, cu, s, v);
    check("R5 R6 R8 word after op", csr_q, m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wmask = '0;
    for (int i = 0; i < 32; i++)
      if (i <= 16 || i == 23 || i >= 25) wmask[i] = 1'b1;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R10
    check("R1 reset word", csr_q, 32'd0);
    check("R1 reset mode", {30'd0, round_mode}, 32'd0);
    check("R10 idle trap", {31'd0, trap_req}, 32'd0);
    check("R10 idle commit", {31'd0, commit_en}, 32'd0);

    // R3 reserved bits and foreign index
    do_write(5'd31, 32'hFFFF_FFFF);
    do_write(5'd31, 32'h0000_0000);
    do_write(5'd5, 32'hFFFF_FFFF);
    do_write(5'd0, 32'h1234_5678);
    check("R3 foreign write ignored", csr_q, 32'd0);

    // R2 read sweep
    do_write(5'd31, 32'hA5C3_0F5A);
    for (int i = 0; i < 32; i++) begin
      cr_idx = 5'(i);
      #1;
      check("R2 read index", cr_rdata, (i == 31) ? m : 32'd0);
    end
    cr_idx = 5'd31;

    // R4 rounding modes
    for (int r = 0; r < 4; r++) begin
      do_write(5'd31, 32'(r));
      check("R4 round_mode", {30'd0, round_mode}, 32'(r));
    end

    // R5 R7 R8: every enable pattern against every exception report
    for (int en = 0; en < 32; en++) begin
      for (int e = 0; e < 32; e++) begin
        do_write(5'd31, 32'(en) << 7);
        do_op(5'(e), 1'b1, e % 8, e[0] ^ en[0]);
      end
    end

    // R6 flags accumulate, then a clean op leaves them
    do_write(5'd31, 32'd0);
    for (int b = 0; b < 5; b++) begin
      do_op(5'(1 << b), 1'b0, 0, 1'b0);
      check("R6 flags accumulate", {27'd0, csr_q[6:2]}, 32'((1 << (b + 1)) - 1));
    end
    do_op(5'd0, 1'b0, 0, 1'b0);
    check("R6 flags kept", {27'd0, csr_q[6:2]}, 32'd31);
    check("R5 cause cleared", {27'd0, csr_q[16:12]}, 32'd0);

    // R8 condition select sweep
    do_write(5'd31, 32'd0);
    for (int s = 0; s < 8; s++) do_op(5'd0, 1'b1, s, 1'b1);
    check("R8 all condition bits set", csr_q & 32'hFE80_0000, 32'hFE80_0000);
    for (int s = 0; s < 8; s++) do_op(5'd0, 1'b1, s, 1'b0);
    check("R8 all condition bits clear", csr_q & 32'hFE80_0000, 32'd0);

    // R9 software-raised trap: divide-by-zero cause with its enable
    do_write(5'd31, (32'h8 << 12) | (32'h8 << 7));

    // R11 write and op in the same cycle
    @(negedge clk);
    cr_wr_en = 1'b1; cr_idx = 5'd31; cr_wdata = (32'h1 << 7) | 32'h2;
    op_done = 1'b1; op_exc = 5'h5; cond_upd_en = 1'b1; cond_sel = 3'd2; cond_val = 1'b1;
    #1;
    check("R11 trap uses written enables", {31'd0, trap_req}, 32'd1);
    check("R11 commit blocked", {31'd0, commit_en}, 32'd0);
    @(negedge clk);
    cr_wr_en = 1'b0; op_done = 1'b0; cond_upd_en = 1'b0;
    m = apply_op(cr_wdata & wmask, 5'h5, 1'b1, 2, 1'b1);
    check("R11 word after combined cycle", csr_q, m);
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule